// File: doc/BRIEF.md
# Byte-Packing Transfer FIFO

This block sits between a 16-bit host register port and a byte-wide serial bus engine. It keeps a single four-byte shift register that serves both transfer directions, with a separate byte count for each direction. When the host writes transmit data, whole halfwords or single bytes are shifted in at the bottom of the register. The engine then takes bytes from the most significant occupied lane downward. Bytes received by the engine are placed from the least significant lane upward. Host reads return the two low bytes and shift the remaining bytes down.

An endianness control input selects the byte order of each halfword as it crosses the host port. The block never updates the register from the host and the engine in the same cycle. When both ask, the host wins and the engine request for that cycle is dropped, so the engine retries it. Status effects are reported as one-cycle pulses so that a status register elsewhere can set or clear its bits. One pulse flags that a read returned a lone leftover byte. The others clear transmit underflow, transmit ready, receive overrun and receive ready. A clear input empties the store at the start of every new transfer.

Top module: `bytepack_fifo`

## Requirements
- R1: After reset both byte counts are 0, every status pulse is low, the register reads as 0x0000, transmit data is not available and receive space is available.
- R2: A 16-bit host write that is accepted shifts the register left by 16 bits and adds 2 to the transmit count. With `big_end_i` = 1 the low halfword of the register takes the written value unchanged, so the high byte of the write is transmitted first. With `big_end_i` = 0 the two bytes are swapped before they are inserted, so the low byte of the write is transmitted first.
- R3: An 8-bit host write (`host_wr_byte_i` = 1) that is accepted shifts the register left by 8 bits, places `host_wdata_i[7:0]` in lane 0 and adds 1 to the transmit count.
- R4: A host write of either width is rejected when the transmit count is above 2. A rejected write leaves the register, the transmit count and every status pulse unchanged, and the transmit count never exceeds 4.
- R5: `eng_tx_byte_o` always shows lane (transmit count − 1), where lane k is bits [8k+7:8k]. Each engine pop decrements the transmit count. A pop while the transmit count is 0 is ignored.
- R6: Each engine push ORs `eng_rx_byte_i` into the lane whose index equals the receive count, then increments that count. A push while 4 bytes are held is ignored.
- R7: `host_rdata_o` shows {lane1, lane0} when `big_end_i` = 0 and {lane0, lane1} when `big_end_i` = 1. A host read while more than 2 bytes are held shifts the register right by 16 bits. A host read while 2 or more bytes are held subtracts 2 from the receive count.
- R8: A host read while exactly one received byte is held sets the receive count to 0 and raises `sts_single_o` in the following cycle. No other read raises it.
- R9: In the cycle after an accepted host write, `sts_txudf_clr_o` pulses, and `sts_txrdy_clr_o` also pulses when the new transmit count is above 2. In the cycle after a host read, `sts_rovr_clr_o` pulses, and `sts_rxrdy_clr_o` also pulses when the receive count after the read is 0.
- R10: In a cycle with a host write or a host read, engine pops and pushes have no effect. When a write and a read arrive together, only the write takes effect.
- R11: `clear_i` zeroes the register and both counts at the next edge and overrides every other request in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Empty the store (start of a new transfer) |
| big_end_i | input | 1 | Halfword byte-order select for host accesses |
| host_wr_i | input | 1 | Host write strobe |
| host_wr_byte_i | input | 1 | 1 = 8-bit write, 0 = 16-bit write |
| host_wdata_i | input | 16 | Host write data |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | 16 | Host read data (low two lanes, ordered per big_end_i) |
| eng_tx_pop_i | input | 1 | Engine takes one transmit byte |
| eng_tx_byte_o | output | 8 | Next transmit byte |
| eng_tx_avail_o | output | 1 | At least one transmit byte queued |
| eng_rx_push_i | input | 1 | Engine delivers one received byte |
| eng_rx_byte_i | input | 8 | Received byte |
| eng_rx_space_o | output | 1 | Receive side has room for a byte |
| tx_count_o | output | 3 | Transmit byte count |
| rx_count_o | output | 3 | Receive byte count |
| sts_single_o | output | 1 | Pulse: read returned a lone byte |
| sts_txudf_clr_o | output | 1 | Pulse: clear transmit underflow |
| sts_txrdy_clr_o | output | 1 | Pulse: clear transmit ready |
| sts_rovr_clr_o | output | 1 | Pulse: clear receive overrun |
| sts_rxrdy_clr_o | output | 1 | Pulse: clear receive ready |

## Verification
The bench builds the block with its default of four lanes, which is the only depth at which the over-2 rejection limit and the single-byte flag act as specified. With four lanes, a short directed sequence can fill the store to capacity and hit the rejection edge after either a halfword or a third single byte. The same depth puts the receive-full drop, the lone-byte read and the read-versus-write and host-versus-engine collisions within reach, each within a handful of cycles after a clear.

// File: rtl/bytepack_pkg.sv
package bytepack_pkg;

    localparam int BYTE_W     = 8;
    localparam int HOST_BYTES = 2;
    localparam int HOST_W     = BYTE_W * HOST_BYTES;

    // which side owns the shared register in a given cycle
    typedef enum logic [1:0] {
        OP_ENGINE  = 2'd0,
        OP_HOST_WR = 2'd1,
        OP_HOST_RD = 2'd2
    } op_e;

    typedef struct packed {
        logic single_set;
        logic txudf_clr;
        logic txrdy_clr;
        logic rovr_clr;
        logic rxrdy_clr;
    } sts_pulse_t;

    function automatic logic [HOST_W-1:0] swap_half(input logic [HOST_W-1:0] v);
        return {v[BYTE_W-1:0], v[HOST_W-1:BYTE_W]};
    endfunction

endpackage

// File: rtl/bp_wr_pack.sv
module bp_wr_pack
    import bytepack_pkg::*;
#(
    parameter int LANES = 4,
    localparam int DW = LANES * BYTE_W,
    localparam int CW = $clog2(LANES + 1)
) (
    input  logic [DW-1:0]     data_q,
    input  logic [CW-1:0]     tx_cnt_q,
    input  logic [HOST_W-1:0] wdata,
    input  logic              byte_mode,
    input  logic              big_end,
    output logic              accept,
    output logic [DW-1:0]     data_n,
    output logic [CW-1:0]     tx_cnt_n
);
    localparam int LIMIT = LANES - HOST_BYTES;

    logic [HOST_W-1:0] half;

    always_comb begin
        half     = big_end ? wdata : swap_half(wdata);
        accept   = (int'(tx_cnt_q) <= LIMIT);
        data_n   = data_q;
        tx_cnt_n = tx_cnt_q;
        if (accept) begin
            if (byte_mode) begin
                data_n   = {data_q[DW-BYTE_W-1:0], wdata[BYTE_W-1:0]};
                tx_cnt_n = tx_cnt_q + CW'(1);
            end else begin
                data_n   = {data_q[DW-HOST_W-1:0], half};
                tx_cnt_n = tx_cnt_q + CW'(HOST_BYTES);
            end
        end
    end
endmodule

// File: rtl/bp_rd_unpack.sv
module bp_rd_unpack
    import bytepack_pkg::*;
#(
    parameter int LANES = 4,
    localparam int DW = LANES * BYTE_W,
    localparam int CW = $clog2(LANES + 1)
) (
    input  logic [DW-1:0]     data_q,
    input  logic [CW-1:0]     rx_cnt_q,
    input  logic              big_end,
    output logic [HOST_W-1:0] rdata,
    output logic              single,
    output logic              empty_after,
    output logic [DW-1:0]     data_n,
    output logic [CW-1:0]     rx_cnt_n
);
    always_comb begin
        rdata    = big_end ? swap_half(data_q[HOST_W-1:0]) : data_q[HOST_W-1:0];
        single   = (rx_cnt_q == CW'(1));
        data_n   = data_q;
        rx_cnt_n = rx_cnt_q;
        if (single) begin
            rx_cnt_n = '0;
        end else if (rx_cnt_q >= CW'(HOST_BYTES)) begin
            if (rx_cnt_q > CW'(HOST_BYTES)) begin
                data_n = data_q >> HOST_W;
            end
            rx_cnt_n = rx_cnt_q - CW'(HOST_BYTES);
        end
        empty_after = (rx_cnt_n == '0);
    end
endmodule

// File: rtl/bp_lane_mux.sv
module bp_lane_mux
    import bytepack_pkg::*;
#(
    parameter int LANES = 4,
    localparam int DW = LANES * BYTE_W,
    localparam int CW = $clog2(LANES + 1)
) (
    input  logic [DW-1:0]     data_q,
    input  logic [CW-1:0]     tx_cnt_q,
    input  logic [CW-1:0]     rx_cnt_q,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [DW-1:0]     rx_data_n
);
    logic [BYTE_W-1:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = data_q[g*BYTE_W +: BYTE_W];
        assign rx_data_n[g*BYTE_W +: BYTE_W] =
            lane[g] | ((int'(rx_cnt_q) == g) ? rx_byte : {BYTE_W{1'b0}});
    end

    // transmit drains from the highest occupied lane
    always_comb begin
        tx_byte = '0;
        for (int i = 0; i < LANES; i++) begin
            if (int'(tx_cnt_q) == i + 1) tx_byte = lane[i];
        end
    end
endmodule

// File: rtl/bytepack_fifo.sv
module bytepack_fifo
    import bytepack_pkg::*;
#(
    parameter int LANES = 4,
    localparam int DW = LANES * BYTE_W,
    localparam int CW = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              big_end_i,
    input  logic              host_wr_i,
    input  logic              host_wr_byte_i,
    input  logic [HOST_W-1:0] host_wdata_i,
    input  logic              host_rd_i,
    output logic [HOST_W-1:0] host_rdata_o,
    input  logic              eng_tx_pop_i,
    output logic [BYTE_W-1:0] eng_tx_byte_o,
    output logic              eng_tx_avail_o,
    input  logic              eng_rx_push_i,
    input  logic [BYTE_W-1:0] eng_rx_byte_i,
    output logic              eng_rx_space_o,
    output logic [CW-1:0]     tx_count_o,
    output logic [CW-1:0]     rx_count_o,
    output logic              sts_single_o,
    output logic              sts_txudf_clr_o,
    output logic              sts_txrdy_clr_o,
    output logic              sts_rovr_clr_o,
    output logic              sts_rxrdy_clr_o
);
    logic [DW-1:0] data_q, data_n;
    logic [CW-1:0] tx_q, tx_n, rx_q, rx_n;
    sts_pulse_t    sts_q, sts_n;
    op_e           op;

    logic          wr_accept;
    logic [DW-1:0] wr_data_n, rd_data_n, push_data_n;
    logic [CW-1:0] wr_tx_n, rd_rx_n;
    logic          rd_single, rd_empty;
    logic          pop_ok, push_ok;

    bp_wr_pack #(.LANES(LANES)) u_wr (
        .data_q   (data_q),
        .tx_cnt_q (tx_q),
        .wdata    (host_wdata_i),
        .byte_mode(host_wr_byte_i),
        .big_end  (big_end_i),
        .accept   (wr_accept),
        .data_n   (wr_data_n),
        .tx_cnt_n (wr_tx_n)
    );

    bp_rd_unpack #(.LANES(LANES)) u_rd (
        .data_q     (data_q),
        .rx_cnt_q   (rx_q),
        .big_end    (big_end_i),
        .rdata      (host_rdata_o),
        .single     (rd_single),
        .empty_after(rd_empty),
        .data_n     (rd_data_n),
        .rx_cnt_n   (rd_rx_n)
    );

    bp_lane_mux #(.LANES(LANES)) u_mux (
        .data_q   (data_q),
        .tx_cnt_q (tx_q),
        .rx_cnt_q (rx_q),
        .rx_byte  (eng_rx_byte_i),
        .tx_byte  (eng_tx_byte_o),
        .rx_data_n(push_data_n)
    );

    // host has priority; a write beats a read
    always_comb begin
        if (host_wr_i)      op = OP_HOST_WR;
        else if (host_rd_i) op = OP_HOST_RD;
        else                op = OP_ENGINE;
    end

    assign pop_ok  = (op == OP_ENGINE) && eng_tx_pop_i  && (tx_q != '0);
    assign push_ok = (op == OP_ENGINE) && eng_rx_push_i && (rx_q != CW'(LANES));

    always_comb begin
        data_n = data_q;
        tx_n   = tx_q;
        rx_n   = rx_q;
        sts_n  = '0;
        unique case (op)
            OP_HOST_WR: begin
                data_n          = wr_data_n;
                tx_n            = wr_tx_n;
                sts_n.txudf_clr = wr_accept;
                sts_n.txrdy_clr = wr_accept && (wr_tx_n > CW'(HOST_BYTES));
            end
            OP_HOST_RD: begin
                data_n           = rd_data_n;
                rx_n             = rd_rx_n;
                sts_n.single_set = rd_single;
                sts_n.rovr_clr   = 1'b1;
                sts_n.rxrdy_clr  = rd_empty;
            end
            default: begin
                if (pop_ok) tx_n = tx_q - CW'(1);
                if (push_ok) begin
                    data_n = push_data_n;
                    rx_n   = rx_q + CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            data_q <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            sts_q  <= '0;
        end else begin
            data_q <= data_n;
            tx_q   <= tx_n;
            rx_q   <= rx_n;
            sts_q  <= sts_n;
        end
    end

    assign eng_tx_avail_o  = (tx_q != '0);
    assign eng_rx_space_o  = (rx_q != CW'(LANES));
    assign tx_count_o      = tx_q;
    assign rx_count_o      = rx_q;
    assign sts_single_o    = sts_q.single_set;
    assign sts_txudf_clr_o = sts_q.txudf_clr;
    assign sts_txrdy_clr_o = sts_q.txrdy_clr;
    assign sts_rovr_clr_o  = sts_q.rovr_clr;
    assign sts_rxrdy_clr_o = sts_q.rxrdy_clr;
endmodule

// File: rtl/bytepack_fifo_chk.sv
module bytepack_fifo_chk #(
    parameter int LANES = 4,
    localparam int CW = $clog2(LANES + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          clear_i,
    input logic          host_wr_i,
    input logic          host_wr_byte_i,
    input logic          host_rd_i,
    input logic          eng_tx_pop_i,
    input logic          eng_rx_push_i,
    input logic [CW-1:0] tx_count_o,
    input logic [CW-1:0] rx_count_o,
    input logic          sts_single_o,
    input logic          sts_txudf_clr_o
);
    localparam int LIMIT = LANES - 2;

    assert_tx_bound_R4: assert property (@(posedge clk) disable iff (rst)
        tx_count_o <= CW'(LANES));

    assert_wr_reject_R4: assert property (@(posedge clk) disable iff (rst)
        (host_wr_i && !clear_i && tx_count_o > CW'(LIMIT))
        |=> (tx_count_o == $past(tx_count_o)) && !sts_txudf_clr_o);

    assert_pop_R5: assert property (@(posedge clk) disable iff (rst)
        (eng_tx_pop_i && !host_wr_i && !host_rd_i && !clear_i && tx_count_o != '0)
        |=> tx_count_o == $past(tx_count_o) - CW'(1));

    assert_rx_full_R6: assert property (@(posedge clk) disable iff (rst)
        (eng_rx_push_i && !host_wr_i && !host_rd_i && !clear_i && rx_count_o == CW'(LANES))
        |=> rx_count_o == CW'(LANES));

    assert_single_R8: assert property (@(posedge clk) disable iff (rst)
        (host_rd_i && !host_wr_i && !clear_i && rx_count_o == CW'(1))
        |=> sts_single_o && rx_count_o == '0);

    assert_host_pri_R10: assert property (@(posedge clk) disable iff (rst)
        (host_wr_i && !host_wr_byte_i && eng_tx_pop_i && !clear_i && tx_count_o <= CW'(LIMIT))
        |=> tx_count_o == $past(tx_count_o) + CW'(2));

    assert_clear_R11: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (tx_count_o == '0) && (rx_count_o == '0));
endmodule

bind bytepack_fifo bytepack_fifo_chk #(.LANES(LANES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .clear_i        (clear_i),
    .host_wr_i      (host_wr_i),
    .host_wr_byte_i (host_wr_byte_i),
    .host_rd_i      (host_rd_i),
    .eng_tx_pop_i   (eng_tx_pop_i),
    .eng_rx_push_i  (eng_rx_push_i),
    .tx_count_o     (tx_count_o),
    .rx_count_o     (rx_count_o),
    .sts_single_o   (sts_single_o),
    .sts_txudf_clr_o(sts_txudf_clr_o)
);

// File: tb/bytepack_fifo_tb.sv
`timescale 1ns/1ps
module bytepack_fifo_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clear_i = 1'b0, big_end_i = 1'b0;
    logic        host_wr_i = 1'b0, host_wr_byte_i = 1'b0, host_rd_i = 1'b0;
    logic [15:0] host_wdata_i = '0;
    logic [15:0] host_rdata_o;
    logic        eng_tx_pop_i = 1'b0, eng_rx_push_i = 1'b0;
    logic [7:0]  eng_rx_byte_i = '0;
    logic [7:0]  eng_tx_byte_o;
    logic        eng_tx_avail_o, eng_rx_space_o;
    logic [2:0]  tx_count_o, rx_count_o;
    logic        sts_single_o, sts_txudf_clr_o, sts_txrdy_clr_o, sts_rovr_clr_o, sts_rxrdy_clr_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bytepack_fifo u_dut (.*);

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic bm, input logic [15:0] v);
        host_wr_i = 1'b1; host_wr_byte_i = bm; host_wdata_i = v;
        step();
        host_wr_i = 1'b0; host_wr_byte_i = 1'b0;
    endtask

    task automatic rd(output logic [15:0] d);
        host_rd_i = 1'b1;
        d = host_rdata_o;
        step();
        host_rd_i = 1'b0;
    endtask

    task automatic pop_expect(input string tag, input logic [7:0] exp);
        chk(tag, eng_tx_byte_o, exp);
        eng_tx_pop_i = 1'b1;
        step();
        eng_tx_pop_i = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        eng_rx_push_i = 1'b1; eng_rx_byte_i = b;
        step();
        eng_rx_push_i = 1'b0;
    endtask

    task automatic do_clear();
        clear_i = 1'b1;
        step();
        clear_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 tx count", tx_count_o, 0);
        chk("R1 rx count", rx_count_o, 0);
        chk("R1 rdata", host_rdata_o, 16'h0000);
        chk("R1 avail", eng_tx_avail_o, 0);
        chk("R1 space", eng_rx_space_o, 1);
        chk("R1 pulses", {sts_single_o, sts_txudf_clr_o, sts_txrdy_clr_o, sts_rovr_clr_o, sts_rxrdy_clr_o}, 0);
    endtask

    task automatic t_wr16_order();
        do_clear();
        big_end_i = 1'b0;
        wr(1'b0, 16'hA1B2);
        chk("R2 tx count", tx_count_o, 2);
        chk("R9 txudf pulse", sts_txudf_clr_o, 1);
        chk("R9 no txrdy pulse", sts_txrdy_clr_o, 0);
        pop_expect("R2 le first", 8'hB2);
        chk("R5 count after pop", tx_count_o, 1);
        pop_expect("R2 le second", 8'hA1);
        pop_expect("R5 pop at empty", 8'h00);
        chk("R5 empty pop ignored", tx_count_o, 0);
        do_clear();
        big_end_i = 1'b1;
        wr(1'b0, 16'hA1B2);
        pop_expect("R2 be first", 8'hA1);
        pop_expect("R2 be second", 8'hB2);
        big_end_i = 1'b0;
    endtask

    task automatic t_fill_reject();
        do_clear();
        wr(1'b0, 16'h2211);
        wr(1'b0, 16'h4433);
        chk("R2 full count", tx_count_o, 4);
        chk("R9 txrdy pulse", sts_txrdy_clr_o, 1);
        wr(1'b0, 16'h6655);
        chk("R4 rejected count", tx_count_o, 4);
        chk("R4 no txudf pulse", sts_txudf_clr_o, 0);
        pop_expect("R4 lane3", 8'h11);
        pop_expect("R4 lane2", 8'h22);
        pop_expect("R4 lane1", 8'h33);
        pop_expect("R4 lane0", 8'h44);
    endtask

    task automatic t_byte_writes();
        do_clear();
        wr(1'b1, 16'hFF01);
        wr(1'b1, 16'hFF02);
        chk("R3 count 2", tx_count_o, 2);
        wr(1'b1, 16'hFF03);
        chk("R3 count 3", tx_count_o, 3);
        chk("R9 txrdy on third byte", sts_txrdy_clr_o, 1);
        wr(1'b1, 16'hFF04);
        chk("R4 byte rejected", tx_count_o, 3);
        wr(1'b0, 16'h7777);
        chk("R4 half rejected", tx_count_o, 3);
        pop_expect("R3 byte a", 8'h01);
        pop_expect("R3 byte b", 8'h02);
        pop_expect("R3 byte c", 8'h03);
        do_clear();
        big_end_i = 1'b1;
        wr(1'b1, 16'h005A);
        wr(1'b0, 16'h1234);
        chk("R3 mixed count", tx_count_o, 3);
        pop_expect("R3 mixed a", 8'h5A);
        pop_expect("R3 mixed b", 8'h12);
        pop_expect("R3 mixed c", 8'h34);
        big_end_i = 1'b0;
    endtask

    task automatic t_receive();
        logic [15:0] d;
        do_clear();
        push(8'h11); push(8'h22); push(8'h33); push(8'h44);
        chk("R6 rx full", rx_count_o, 4);
        chk("R6 no space", eng_rx_space_o, 0);
        push(8'hFF);
        chk("R6 push at full ignored", rx_count_o, 4);
        rd(d);
        chk("R7 first half", d, 16'h2211);
        chk("R7 count after read", rx_count_o, 2);
        chk("R9 rovr pulse", sts_rovr_clr_o, 1);
        chk("R9 no rxrdy pulse", sts_rxrdy_clr_o, 0);
        rd(d);
        chk("R7 second half", d, 16'h4433);
        chk("R7 rx empty", rx_count_o, 0);
        chk("R9 rxrdy pulse", sts_rxrdy_clr_o, 1);
        chk("R8 no single", sts_single_o, 0);
        do_clear();
        big_end_i = 1'b1;
        push(8'hAA); push(8'hBB);
        rd(d);
        chk("R7 be order", d, 16'hAABB);
        big_end_i = 1'b0;
    endtask

    task automatic t_single();
        logic [15:0] d;
        do_clear();
        push(8'h5C);
        rd(d);
        chk("R8 lone data", d, 16'h005C);
        chk("R8 single pulse", sts_single_o, 1);
        chk("R8 count zero", rx_count_o, 0);
        chk("R9 rxrdy on lone", sts_rxrdy_clr_o, 1);
        rd(d);
        chk("R8 empty read no flag", sts_single_o, 0);
    endtask

    task automatic t_priority();
        do_clear();
        wr(1'b0, 16'h1111);
        eng_tx_pop_i = 1'b1;
        wr(1'b0, 16'h2222);
        eng_tx_pop_i = 1'b0;
        chk("R10 pop dropped on write", tx_count_o, 4);
        do_clear();
        host_rd_i = 1'b1;
        push(8'h99);
        host_rd_i = 1'b0;
        chk("R10 push dropped on read", rx_count_o, 0);
        do_clear();
        push(8'h10); push(8'h20);
        host_rd_i = 1'b1;
        wr(1'b0, 16'h3344);
        host_rd_i = 1'b0;
        chk("R10 write wins tx", tx_count_o, 2);
        chk("R10 write wins rx", rx_count_o, 2);
        chk("R10 no rovr pulse", sts_rovr_clr_o, 0);
    endtask

    task automatic t_clear();
        do_clear();
        wr(1'b0, 16'hBEEF);
        push(8'h01);
        clear_i = 1'b1;
        wr(1'b0, 16'h1234);
        clear_i = 1'b0;
        chk("R11 tx cleared", tx_count_o, 0);
        chk("R11 rx cleared", rx_count_o, 0);
        chk("R11 data cleared", host_rdata_o, 16'h0000);
        chk("R11 no pulse", sts_txudf_clr_o, 0);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_wr16_order();
        t_fill_reject();
        t_byte_writes();
        t_receive();
        t_single();
        t_priority();
        t_clear();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule